// File: doc/BRIEF.md
# Mid-Eye Serial-to-Parallel Receiver

This block turns a single-line serial bit stream, one bit per fast clock period, into parallel words for logic that runs at a fraction of that rate. The line is sampled on the falling edge of the fast clock, so the sample lands half a period away from the edges where the bits change. The sampled bits then pass through a fast-clock shift register. On every rising edge of a slower clock, a parallel output register takes a copy of the shift register's contents.

The deserialization ratio is a parameter and may be 2, 4 or 8. The word width equals the ratio. The slow clock can come from either of two sources. It can be made inside the block by a counter on the fast clock, which suits a system with a single clock source. It can also be taken from an input pin that is driven by an aligned, already-divided clock. In both cases the slow clock is driven out so that downstream logic can run on it. The block does not search for word alignment. The word boundary is set by the phase of the slow clock, so the source must line up its frames with that phase.

The data path is fixed-rate and has no valid/ready handshake. Nothing can push back: a new word appears once every slow period, and the consumer must take each word before the next slow rising edge. In pin mode, the slow rising edge must follow its matching fast rising edge by less than one fast period.

Top module: `rxd_deser`

## Requirements
- R1: While `rst` is high, `word_out` is 0 whatever `ser_in` does, and in divider mode `clk_slow_out` is low.
- R2: `ser_in` is sampled only at the falling edge of `clk_fast`. A value that changes after that edge and before the next rising edge has no effect on the word.
- R3: Bits enter the word at bit 0 and move toward the top, so the earliest bit of a word sits in bit RATIO-1 and the latest in bit 0.
- R4: In divider mode (`SLOW_SRC` = 0), `clk_slow_out` is low for the first RATIO/2 fast rising edges after reset release. It then goes high on fast rising edge number RATIO/2 and repeats with a period of RATIO fast cycles and a high phase of RATIO/2 cycles.
- R5: `word_out` changes only at a rising edge of the slow clock and holds its value for the rest of the slow period.
- R6: Number the fast rising edges after reset release from 0, with edge 0 still in reset, and let bit k be the value on `ser_in` across falling edge k. The word loaded at a slow rising edge aligned with fast edge i then holds bits i-RATIO to i-1, earliest in the MSB.
- R7: In the first word after reset release, the positions that belong to bit indices below 0 read 0.
- R8: In pin mode (`SLOW_SRC` = 1), `clk_slow_out` follows `clk_slow_in`, and words of RATIO bits are loaded on its rising edges under the rule of R6.
- R9: Raising `rst` in the middle of a stream clears `word_out` at once, without waiting for a clock edge. After release, the divider starts again from the phase given in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Bit-rate clock; falling edge samples the line, rising edge shifts |
| clk_slow_in | input | 1 | Aligned word-rate clock, used only in pin mode |
| rst | input | 1 | Active-high asynchronous reset |
| ser_in | input | 1 | Serial data line, one bit per fast period |
| word_out | output | RATIO | Parallel word, earliest bit in the MSB |
| clk_slow_out | output | 1 | Word-rate clock for downstream logic |

## Verification
Each internal register fault has a specific effect at the ports, and the checks are built to catch those effects. If the capture flop used the wrong edge, the word would change when a mid-bit glitch is driven after the falling edge, and this shows up in the very next word. If the shift register were reversed or off by one stage, a marked bit would appear in the wrong position in the first complete word. A fault in the divider phase shows on `clk_slow_out` within RATIO fast cycles of reset release, and it also moves every word boundary. A parallel register that loads at the wrong time shows up as a word that changes in the middle of a slow period.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  // Where the word-rate clock comes from.
  typedef enum logic {
    SLOW_FROM_DIV = 1'b0,  // made here by a counter on the fast clock
    SLOW_FROM_PIN = 1'b1   // supplied on clk_slow_in, already aligned
  } slow_src_e;

  // Bits needed by a counter that wraps after ratio fast cycles.
  function automatic int unsigned div_cnt_bits(input int unsigned ratio);
    return (ratio <= 2) ? 1 : $clog2(ratio);
  endfunction

endpackage

// File: rtl/rxd_capture.sv
// Samples the line half a bit after the launch edge.
module rxd_capture (
  input  logic clk_fast,
  input  logic rst,
  input  logic line_in,
  output logic bit_q
);

  always_ff @(negedge clk_fast or posedge rst) begin
    if (rst) bit_q <= 1'b0;
    else     bit_q <= line_in;
  end

endmodule

// File: rtl/rxd_sipo.sv
// Fast-clock shift register: new bit in at bit 0, oldest at the top.
module rxd_sipo #(
  parameter int unsigned W = 8
) (
  input  logic         clk_fast,
  input  logic         rst,
  input  logic         bit_in,
  output logic [W-1:0] shift_q
);

  always_ff @(posedge clk_fast or posedge rst) begin
    if (rst) shift_q <= '0;
    else     shift_q <= {shift_q[W-2:0], bit_in};
  end

endmodule

// File: rtl/rxd_clkdiv.sv
// Word-rate clock from the fast clock; the output is a single flop bit.
module rxd_clkdiv
  import rxd_pkg::*;
#(
  parameter int unsigned RATIO = 8
) (
  input  logic clk_fast,
  input  logic rst,
  output logic div_clk
);

  localparam int unsigned CW   = div_cnt_bits(RATIO);
  localparam int unsigned HALF = RATIO / 2;

  logic [CW-1:0] phase_q;

  always_ff @(posedge clk_fast or posedge rst) begin
    if (rst) phase_q <= '0;
    else     phase_q <= phase_q + 1'b1;
  end

  assign div_clk = phase_q[CW-1];

  // R4
  slow_high_len_chk: assert property (@(posedge clk_fast) disable iff (rst)
    $fell(div_clk) |-> ($past(div_clk, HALF) && !$past(div_clk, HALF + 1)))
    else $error("slow clock high phase is not RATIO/2 fast cycles");

endmodule

// File: rtl/rxd_word_reg.sv
// Parallel output register on the word-rate clock.
module rxd_word_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_slow,
  input  logic         rst,
  input  logic [W-1:0] shift_in,
  output logic [W-1:0] word_q
);

  always_ff @(posedge clk_slow or posedge rst) begin
    if (rst) word_q <= '0;
    else     word_q <= shift_in;
  end

endmodule

// File: rtl/rxd_deser.sv
module rxd_deser
  import rxd_pkg::*;
#(
  parameter int unsigned RATIO    = 8,
  parameter slow_src_e   SLOW_SRC = SLOW_FROM_DIV
) (
  input  logic             clk_fast,
  input  logic             clk_slow_in,
  input  logic             rst,
  input  logic             ser_in,
  output logic [RATIO-1:0] word_out,
  output logic             clk_slow_out
);

  localparam int unsigned W = RATIO;

  logic         cap_bit;
  logic [W-1:0] shift_w;
  logic         slow_clk;

  rxd_capture u_cap (
    .clk_fast (clk_fast),
    .rst      (rst),
    .line_in  (ser_in),
    .bit_q    (cap_bit)
  );

  rxd_sipo #(.W(W)) u_sipo (
    .clk_fast (clk_fast),
    .rst      (rst),
    .bit_in   (cap_bit),
    .shift_q  (shift_w)
  );

  generate
    if (SLOW_SRC == SLOW_FROM_DIV) begin : g_div
      rxd_clkdiv #(.RATIO(RATIO)) u_div (
        .clk_fast (clk_fast),
        .rst      (rst),
        .div_clk  (slow_clk)
      );
      logic unused_slow_pin;
      assign unused_slow_pin = clk_slow_in;
    end else begin : g_pin
      assign slow_clk = clk_slow_in;
    end
  endgenerate

  rxd_word_reg #(.W(W)) u_word (
    .clk_slow (slow_clk),
    .rst      (rst),
    .shift_in (shift_w),
    .word_q   (word_out)
  );

  assign clk_slow_out = slow_clk;

  // R1
  reset_clear_chk: assert property (@(posedge clk_fast)
    rst |-> ((word_out == '0) && (shift_w == '0)))
    else $error("state not clear under reset");

  // R5
  word_hold_chk: assert property (@(posedge clk_fast) disable iff (rst)
    !$stable(word_out) |-> $rose(slow_clk))
    else $error("word changed away from a slow rising edge");

  // R6
  word_load_chk: assert property (@(posedge clk_fast) disable iff (rst)
    $rose(slow_clk) |-> (word_out == shift_w))
    else $error("word does not match shift contents at the boundary");

endmodule

// File: tb/rxd_deser_bench.sv
module rxd_deser_bench;
  import rxd_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_in = 1'b0;
  logic slow_ext = 1'b0;
  logic [7:0] word8;
  logic [3:0] word4;
  logic slow8, slow4;

  int n_vec = 0;
  int n_bad = 0;
  logic bits [0:255];
  logic [7:0] snap8;

  always #4 clk = ~clk;

  rxd_deser #(.RATIO(8), .SLOW_SRC(SLOW_FROM_DIV)) u_rxd_deser (
    .clk_fast (clk), .clk_slow_in (1'b0), .rst (rst), .ser_in (ser_in),
    .word_out (word8), .clk_slow_out (slow8)
  );

  rxd_deser #(.RATIO(4), .SLOW_SRC(SLOW_FROM_PIN)) u_rxd_deser_pin (
    .clk_fast (clk), .clk_slow_in (slow_ext), .rst (rst), .ser_in (ser_in),
    .word_out (word4), .clk_slow_out (slow4)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Word for a boundary at fast edge i, ratio r, earliest bit in the MSB.
  function automatic logic [7:0] assemble(input int i, input int r);
    logic [7:0] w;
    w = '0;
    for (int k = 0; k < r; k++) begin
      int idx;
      idx = i - r + k;
      w[r-1-k] = (idx >= 0) ? bits[idx] : 1'b0;
    end
    return w;
  endfunction

  function automatic logic [7:0] lvl(input logic b);
    return {7'd0, b};
  endfunction

  // Reset, then stream n bits starting at fast edge 0; checks every cycle.
  task automatic run_stream(input int n, input bit glitch);
    logic [7:0] hold8, hold4;
    rst = 1'b1; slow_ext = 1'b0; ser_in = 1'b0;
    repeat (3) @(posedge clk);
    hold8 = '0; hold4 = '0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      ser_in = bits[i];
      if (i == 0) rst = 1'b0;
      if (i % 4 == 2) slow_ext = 1'b1;
      else if (i % 4 == 0) slow_ext = 1'b0;
      #1;
      chk("R4 divided clock level", lvl(slow8), ((i % 8) >= 4) ? 8'd1 : 8'd0);
      if (i % 8 == 4) begin
        hold8 = assemble(i, 8);
        if (i == 4) chk("R7 first word after release", word8, hold8);
        else        chk("R6 word at boundary", word8, hold8);
        if (i == 12) snap8 = word8;
      end else begin
        chk("R5 word held between boundaries", word8, hold8);
      end
      chk("R8 slow pin passthrough", lvl(slow4), lvl(slow_ext));
      if (i % 4 == 2) hold4 = assemble(i, 4);
      chk("R8 ratio-4 word", {4'd0, word4}, hold4);
      if (glitch) begin
        #3;  // past the falling edge: this change must not be seen
        ser_in = ~bits[i];
      end
    end
  endtask

  task automatic t_reset_state();
    rst = 1'b1; ser_in = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    chk("R1 word under reset", word8, 8'h00);
    chk("R1 pin-mode word under reset", {4'd0, word4}, 8'h00);
    chk("R1 slow clock under reset", lvl(slow8), 8'd0);
  endtask

  task automatic t_alternating();
    for (int i = 0; i < 256; i++) bits[i] = i[0];
    run_stream(40, 1'b0);
  endtask

  task automatic t_walking();
    for (int i = 0; i < 256; i++) bits[i] = 1'b0;
    bits[4] = 1'b1;   // earliest bit of the word loaded at edge 12
    bits[11] = 1'b1;  // latest bit of that word
    run_stream(24, 1'b0);
    chk("R3 earliest bit in MSB, latest in LSB", snap8, 8'h81);
  endtask

  task automatic t_prbs();
    logic [6:0] lfsr;
    lfsr = 7'h5b;
    for (int i = 0; i < 256; i++) begin
      bits[i] = lfsr[6];
      lfsr = {lfsr[5:0], lfsr[6] ^ lfsr[5]};
    end
    run_stream(64, 1'b0);
  endtask

  task automatic t_midbit_glitch();
    logic [6:0] lfsr;
    lfsr = 7'h23;
    for (int i = 0; i < 256; i++) begin
      bits[i] = lfsr[6];
      lfsr = {lfsr[5:0], lfsr[6] ^ lfsr[5]};
    end
    run_stream(48, 1'b1);  // R2: words must follow the falling-edge values
  endtask

  task automatic t_reset_mid();
    for (int i = 0; i < 256; i++) bits[i] = 1'b1;
    run_stream(30, 1'b0);
    chk("R9 word before mid-stream reset", word8, 8'hff);
    #1 rst = 1'b1;
    #1;
    chk("R9 word cleared at once", word8, 8'h00);
    chk("R9 pin-mode word cleared at once", {4'd0, word4}, 8'h00);
    chk("R9 divider cleared at once", lvl(slow8), 8'd0);
    for (int i = 0; i < 256; i++) bits[i] = (i % 3 == 0);
    run_stream(28, 1'b0);  // divider phase restarts per R4
  endtask

  initial begin
    snap8 = '0;
    t_reset_state();
    t_alternating();
    t_walking();
    t_prbs();
    t_midbit_glitch();
    t_reset_mid();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule